// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave Controller

This block is the command engine on the device side of a three-wire serial EEPROM link with a tri-stated data output. The host selects the device with chip select and clocks instruction bits in on serial data in. Each instruction is a start bit, a two-bit opcode and an address. Read data, and the ready/busy status of self-timed program cycles, come back on the serial data output. A register array stands in for the non-volatile cells. It is organized as 512 x 8 or 256 x 16, and the `WORD16` parameter picks the organization.

The chip select, clock and data inputs come from outside, so the block synchronizes them into the system clock domain and detects their edges there. A write-enable latch gates every modifying command. The `wr_allow_i` input comes from a supply-lockout block and gates them as well. The program/erase time is a count of system clock cycles, set by the `PROG_CYCLES` parameter.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Leading 0 bits on DI while CS is high are ignored. The first 1 sampled on a rising SK edge is the start bit. It is followed by a 2-bit opcode, MSB first, and then the address MSB first: 9 bits for the x8 organization (`WORD16`=0) or 8 bits for x16. All bits are sampled on rising SK.
- R2: Opcode 10 reads, 01 writes and 11 erases one location. With opcode 00, the two top address bits select the operation: 11 enables writing, 00 disables writing, 10 erases all locations and 01 writes all locations. WRITE and WRITE-ALL take DW further data bits, MSB first.
- R3: After the last address bit of a READ, DO is driven with a 0 dummy bit. Each following rising SK edge presents the next data bit, MSB first. The rising edge after the LSB releases DO.
- R4: The write-enable latch is clear after reset. WRITE, ERASE, ERASE-ALL and WRITE-ALL have no effect while it is clear. The enable command sets the latch and the disable command clears it.
- R5: A complete modifying command starts a self-timed cycle at the falling edge of CS, and only if the latch is set and `wr_allow_i` is 1. The cycle lasts `PROG_CYCLES` clocks and needs no SK activity.
- R6: ERASE sets the addressed word to all ones. ERASE-ALL sets every word to all ones. WRITE-ALL stores its data word in every location.
- R7: Once a cycle has started, DO is driven whenever CS is high: 0 while busy and 1 when ready. A 1 sampled on a rising SK edge releases DO at the next falling SK edge.
- R8: READ works whether the write-enable latch is set or clear.
- R9: A command whose CS falls before all of its bits have arrived has no effect and starts no cycle.
- R10: While a cycle is busy, start bits are not accepted, so a whole command sent then has no effect.
- R11: DO is released whenever CS is low.
- R12: After reset, DO is released, no cycle is running, and every array word reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock from the host, asynchronous |
| di_i | input | 1 | Serial data in |
| wr_allow_i | input | 1 | 1 when the supply permits programming |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for DO; 0 means high impedance |

## Verification
The hardest state to reach from the ports is a complete command that arrives while a self-timed cycle is still running. Reaching it needs a cycle long enough to cover a full serial frame. The bench therefore sets `PROG_CYCLES` to 2000 and sends a second WRITE immediately after the CS falling edge of the first. It then reads both addresses to show that only the first write landed. The dummy-1 release of the status output is also awkward to reach. The bench observes it half an SK period apart: still driven after the rising edge and released after the falling edge.

// File: rtl/mw_pkg.sv
// Package mw_pkg
// Shared command type and decode helpers for the serial EEPROM controller.
// Assumes opcode and extended-select bits are presented MSB first.
package mw_pkg;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERASE_ALL,
        CMD_WRITE_ALL,
        CMD_WEN,
        CMD_WDIS
    } cmd_e;

    // Map the opcode and, for opcode 00, the two top address bits to a command.
    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] ext);
        cmd_e c;
        case (opc)
            2'b10:   c = CMD_READ;
            2'b11:   c = CMD_ERASE;
            2'b01:   c = CMD_WRITE;
            default: begin
                case (ext)
                    2'b11:   c = CMD_WEN;
                    2'b00:   c = CMD_WDIS;
                    2'b10:   c = CMD_ERASE_ALL;
                    default: c = CMD_WRITE_ALL;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mw_sync.sv
// Module mw_sync
// Multi-bit flop-chain synchronizer for slow asynchronous control inputs.
// Assumes each bit is independent and held for several clock periods.
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl = stg[STAGES-1];

endmodule

// File: rtl/mw_cmd.sv
// Module mw_cmd
// Serial front end: start-bit hunt, header and data shifting, read shift-out,
// write-enable latch and ready/busy status output.
// Assumes edge strobes are single-cycle pulses in the clk domain.
module mw_cmd
    import mw_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          cs_fall,
    input  logic          sk_rise,
    input  logic          sk_fall,
    input  logic          di,
    input  logic          busy,
    input  logic          wr_allow,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          start_o,
    output cmd_e          cmd_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          wel_o,
    output logic          do_o,
    output logic          oe_o
);

    localparam int CW = $clog2(AW + DW + 4);

    typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_ARMED, S_DONE} st_e;

    st_e           st_q;
    logic [CW-1:0] cnt_q;
    logic [AW:0]   hdr_q;
    logic [AW+1:0] hdr_nxt;
    logic [DW-1:0] dsr_q;
    logic [DW:0]   rsr_q;
    cmd_e          cmd_q;
    cmd_e          cmd_nxt;
    logic [AW-1:0] addr_q;
    logic          wel_q;
    logic          stat_q;
    logic          rel_q;
    logic          hdr_done;

    assign hdr_nxt  = {hdr_q, di};
    assign rd_addr  = hdr_nxt[AW-1:0];
    assign cmd_nxt  = decode_cmd(hdr_nxt[AW+1:AW], hdr_nxt[AW-1:AW-2]);
    assign hdr_done = (st_q == S_HDR) && sk_rise && (cnt_q == CW'(AW + 1));

    // Frame sequencer: hunt the start bit, collect header and data, shift out reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            hdr_q  <= '0;
            dsr_q  <= '0;
            rsr_q  <= '0;
            cmd_q  <= CMD_READ;
            addr_q <= '0;
        end else if (!cs) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else if (sk_rise) begin
            case (st_q)
                S_IDLE: begin
                    if (di && !busy) begin
                        st_q  <= S_HDR;
                        cnt_q <= '0;
                    end
                end
                S_HDR: begin
                    hdr_q <= hdr_nxt[AW:0];
                    cnt_q <= cnt_q + 1'b1;
                    if (hdr_done) begin
                        cmd_q  <= cmd_nxt;
                        addr_q <= rd_addr;
                        cnt_q  <= '0;
                        case (cmd_nxt)
                            CMD_READ: begin
                                st_q  <= S_READ;
                                rsr_q <= {1'b0, rd_data};
                            end
                            CMD_WRITE, CMD_WRITE_ALL: st_q <= S_DATA;
                            CMD_WEN, CMD_WDIS:        st_q <= S_DONE;
                            default:                  st_q <= S_ARMED;
                        endcase
                    end
                end
                S_DATA: begin
                    dsr_q <= {dsr_q[DW-2:0], di};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(DW - 1)) st_q <= S_ARMED;
                end
                S_READ: begin
                    if (cnt_q == CW'(DW)) begin
                        st_q <= S_DONE;
                    end else begin
                        rsr_q <= {rsr_q[DW-1:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Write-enable latch, changed only by the enable and disable commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (hdr_done && cmd_nxt == CMD_WEN) begin
            wel_q <= 1'b1;
        end else if (hdr_done && cmd_nxt == CMD_WDIS) begin
            wel_q <= 1'b0;
        end
    end

    assign start_o = cs_fall && (st_q == S_ARMED) && wel_q && wr_allow;

    // Status output arming and release on a dummy 1 at the following SK fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            rel_q  <= 1'b0;
        end else if (start_o) begin
            stat_q <= 1'b1;
            rel_q  <= 1'b0;
        end else if (!cs) begin
            rel_q <= 1'b0;
        end else if (sk_rise && di && stat_q) begin
            rel_q <= 1'b1;
        end else if (sk_fall && rel_q) begin
            stat_q <= 1'b0;
            rel_q  <= 1'b0;
        end
    end

    assign cmd_o  = cmd_q;
    assign addr_o = addr_q;
    assign data_o = dsr_q;
    assign wel_o  = wel_q;
    assign oe_o   = cs && ((st_q == S_READ) || stat_q);
    assign do_o   = (st_q == S_READ) ? rsr_q[DW] : !busy;

    AST_READ_LEADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_READ && $past(st_q) != S_READ) |-> !do_o); // R3
    AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q == S_IDLE) |=> (st_q == S_IDLE)); // R10

endmodule

// File: rtl/mw_store.sv
// Module mw_store
// Behavioural cell array with the self-timed program/erase engine.
// Assumes start pulses arrive only when not busy; updates commit at cycle end.
module mw_store
    import mw_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 9,
    parameter int PROG_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);

    localparam int DEPTH = 1 << AW;
    localparam int TW    = $clog2(PROG_CYCLES + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [TW-1:0] cnt_q;
    cmd_e          op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          commit;

    // Cycle timer and capture of the operation to perform.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            op_q   <= CMD_READ;
            addr_q <= '0;
            data_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            cnt_q  <= TW'(PROG_CYCLES);
            op_q   <= cmd;
            addr_q <= addr;
            data_q <= data;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == TW'(1)) busy <= 1'b0;
        end
    end

    assign commit = busy && (cnt_q == TW'(1));

    // Array update at the end of a cycle; reset leaves every word erased.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            case (op_q)
                CMD_WRITE:     mem[addr_q] <= data_q;
                CMD_ERASE:     mem[addr_q] <= '1;
                CMD_ERASE_ALL: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                CMD_WRITE_ALL: for (int i = 0; i < DEPTH; i++) mem[i] <= data_q;
                default: ;
            endcase
        end
    end

    assign rd_data = mem[rd_addr];

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(PROG_CYCLES)); // R5
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R10

endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Module mw_eeprom_ctrl
// Top of the serial EEPROM slave: synchronizes CS/SK/DI, detects edges and
// joins the command front end to the self-timed array.
// Assumes SK high and low phases each span several system clocks.
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int WORD16      = 0,
    parameter int PROG_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic wr_allow_i,
    output logic do_o,
    output logic do_oe_o
);

    localparam int DW = (WORD16 != 0) ? 16 : 8;
    localparam int AW = (WORD16 != 0) ? 8 : 9;

    logic [2:0]    lvl;
    logic          cs_s, sk_s, di_s;
    logic          cs_d, sk_d;
    logic          cs_fall, sk_rise, sk_fall;
    logic          start, busy, wel;
    cmd_e          cmd;
    logic [AW-1:0] addr, rd_addr;
    logic [DW-1:0] data, rd_data;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({cs_i, sk_i, di_i}), .lvl(lvl)
    );

    assign {cs_s, sk_s, di_s} = lvl;

    // Delayed copies of the synchronized CS and SK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_d <= cs_s;
            sk_d <= sk_s;
        end
    end

    assign cs_fall = cs_d && !cs_s;
    assign sk_rise = sk_s && !sk_d;
    assign sk_fall = sk_d && !sk_s;

    mw_cmd #(.DW(DW), .AW(AW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs(cs_s), .cs_fall(cs_fall),
        .sk_rise(sk_rise), .sk_fall(sk_fall), .di(di_s), .busy(busy),
        .wr_allow(wr_allow_i), .rd_data(rd_data), .rd_addr(rd_addr),
        .start_o(start), .cmd_o(cmd), .addr_o(addr), .data_o(data),
        .wel_o(wel), .do_o(do_o), .oe_o(do_oe_o)
    );

    mw_store #(.DW(DW), .AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .data(data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    AST_BUSY_FROM_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_fall)); // R5
    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R4
    AST_BUSY_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_allow_i)); // R5

endmodule

// File: tb/mw_eeprom_ctrl_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module mw_eeprom_ctrl_bench;

    localparam int DW   = 8;
    localparam int AW   = 9;
    localparam int PROG = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, allow = 1'b1;
    logic do_w, oe_w;
    int   vectors = 0, miscompares = 0;
    bit   done = 1'b0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] obs_word;
    event        word_ev;

    always #5 clk = ~clk;

    mw_eeprom_ctrl #(.WORD16(0), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_mw_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .wr_allow_i(allow), .do_o(do_w), .do_oe_o(oe_w)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected word and compare with what was shifted out.
    always begin
        @(word_ev);
        if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard empty", int'(obs_word), 0);
        end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(obs_word == e.val, e.tag, int'(obs_word), int'(e.val));
        end
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_hi(logic b);
        di = b; wt(3); sk = 1'b1; wt(6);
    endtask

    task automatic sk_lo;
        sk = 1'b0; wt(6);
    endtask

    task automatic send_bit(logic b);
        sk_hi(b); sk_lo();
    endtask

    task automatic cs_off;
        di = 1'b0; cs = 1'b0; wt(6);
    endtask

    // Start bit, opcode, address; leaves SK high after the last address bit.
    task automatic send_hdr(logic [1:0] op, logic [AW-1:0] a);
        cs = 1'b1; wt(4);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int i = AW - 1; i > 0; i--) send_bit(a[i]);
        sk_hi(a[0]);
    endtask

    task automatic cmd_data(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, int nbits);
        send_hdr(op, a); sk_lo();
        for (int i = DW - 1; i >= DW - nbits; i--) send_bit(d[i]);
        cs_off();
    endtask

    task automatic cmd_plain(logic [1:0] op, logic [AW-1:0] a);
        send_hdr(op, a); sk_lo(); cs_off();
    endtask

    task automatic read_word(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
        logic [15:0] w = '0;
        exp_t e;
        e.val = 16'(exp); e.tag = tag;
        exp_q.push_back(e);
        send_hdr(2'b10, a);
        check(oe_w === 1'b1 && do_w === 1'b0, "R3 dummy zero", {oe_w, do_w}, 2'b10);
        sk_lo();
        for (int i = DW - 1; i >= 0; i--) begin
            sk_hi(1'b0);
            w[i] = do_w;
            sk_lo();
        end
        sk_hi(1'b0);
        check(oe_w === 1'b0, "R3 release after LSB", oe_w, 0);
        sk_lo();
        cs_off();
        obs_word = w;
        ->word_ev;
    endtask

    // Busy, then ready, then dummy-1 release at the SK fall.
    task automatic status_cycle(string tag);
        cs = 1'b1; wt(6);
        check(oe_w === 1'b1 && do_w === 1'b0, {tag, " R7 busy"}, {oe_w, do_w}, 2'b10);
        wt(PROG + 20);
        check(oe_w === 1'b1 && do_w === 1'b1, {tag, " R7 ready"}, {oe_w, do_w}, 2'b11);
        sk_hi(1'b1);
        check(oe_w === 1'b1, {tag, " R7 held until SK fall"}, oe_w, 1);
        sk_lo();
        check(oe_w === 1'b0, {tag, " R7 released"}, oe_w, 0);
        cs_off();
    endtask

    task automatic no_cycle(string tag);
        cs = 1'b1; wt(6);
        check(oe_w === 1'b0, tag, oe_w, 0);
        cs_off();
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(4);
        check(oe_w === 1'b0, "R12 DO released after reset", oe_w, 0);

        // R1 leading zeros ignored; R12 erased array; R8 read while disabled
        cs = 1'b1; wt(4); send_bit(1'b0); send_bit(1'b0);
        read_word(9'd5, 8'hFF, "R1 R12 R8 read after zeros");

        // R4 write without enable has no effect
        cmd_data(2'b01, 9'd5, 8'hA5, DW);
        no_cycle("R4 no cycle when disabled");
        read_word(9'd5, 8'hFF, "R4 write ignored");

        // R2 enable then write; R5 and R7 status
        cmd_plain(2'b00, {2'b11, 7'd0});
        cmd_data(2'b01, 9'd5, 8'hA5, DW);
        status_cycle("R5 write");
        read_word(9'd5, 8'hA5, "R2 R3 write then read");

        // R5 lockout input blocks the cycle
        allow = 1'b0;
        cmd_data(2'b01, 9'd6, 8'h3C, DW);
        no_cycle("R5 no cycle when not allowed");
        allow = 1'b1;
        read_word(9'd6, 8'hFF, "R5 blocked write");

        // R10 a command sent while busy is dropped
        cmd_data(2'b01, 9'd7, 8'h11, DW);
        cmd_data(2'b01, 9'd8, 8'h22, DW);
        wt(PROG + 20);
        read_word(9'd7, 8'h11, "R10 first write lands");
        read_word(9'd8, 8'hFF, "R10 write during busy dropped");

        // R9 truncated write aborts
        cmd_data(2'b01, 9'd9, 8'h00, 3);
        no_cycle("R9 no cycle after abort");
        read_word(9'd9, 8'hFF, "R9 aborted write");

        // R6 erase single location
        cmd_plain(2'b11, 9'd7);
        status_cycle("R6 erase");
        read_word(9'd7, 8'hFF, "R6 erase to ones");

        // R6 write all
        cmd_data(2'b00, {2'b01, 7'd0}, 8'h5A, DW);
        status_cycle("R6 write all");
        read_word(9'd0, 8'h5A, "R6 write all low");
        read_word(9'd511, 8'h5A, "R6 write all high");

        // R6 erase all
        cmd_plain(2'b00, {2'b10, 7'd0});
        status_cycle("R6 erase all");
        read_word(9'd300, 8'hFF, "R6 erase all");

        // R4 disable, then R8 read while disabled
        cmd_data(2'b01, 9'd3, 8'h77, DW);
        status_cycle("R4 still enabled");
        cmd_plain(2'b00, {2'b00, 7'd0});
        cmd_data(2'b01, 9'd3, 8'h12, DW);
        no_cycle("R4 no cycle after disable");
        read_word(9'd3, 8'h77, "R4 R8 read after disable");

        // R11 CS low releases DO mid-read
        send_hdr(2'b10, 9'd3);
        sk_lo();
        cs = 1'b0; wt(6);
        check(oe_w === 1'b0, "R11 DO released on CS low", oe_w, 0);

        wt(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule